// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control unit that sits beside a small 8-bit processor core and steps it through taking an interrupt and coming back from one. It watches the request lines, the global interrupt enable, a strobe that marks the end of each instruction, and a strobe that marks a decoded return-from-interrupt. From these it produces byte-wide stack push and pop requests for the 16-bit program counter, a program-counter load with either the vector address or the restored return address, an acknowledge to the winning request, and a stall for the core.

The timing is exact to the cycle. Entry takes four cycles. In those cycles the return address is pushed as two bytes and the vector is loaded. The jump that sits at the vector then takes two cycles. A return takes four cycles and pops the address back. After every return, one main-program instruction must finish before any pending request can be taken again. The block does not save the status flags; handler software does that.

Top module: `irq_entry_seq`

## Requirements
- R1: When more than one request is pending at recognition, the lowest-numbered one wins, and the vector address loaded on entry equals the winner's index plus one.
- R2: A request is recognised only in a cycle where `insn_done` is high, the block is idle, `gie` is high and `reti_dec` is low. The next four cycles are the entry sequence, and `core_stall` is high in all four. In the first of them, `irq_ack` is one-hot on the winner. Requests are level-held until acknowledged.
- R3: In the second entry cycle, `push_req` is high with the low byte of the `pc_cur` value captured at recognition. In the third, it is high with the high byte.
- R4: In the fourth entry cycle, `pc_load` is high with the vector address. Then follow exactly two cycles with `jmp_phase` high and the stall low, and no request is recognised in those cycles.
- R5: `gie` drops to 0 in the cycle after the acknowledge. It rises to 1 in the cycle after the last return cycle.
- R6: `reti_dec` while idle starts a four-cycle return with `core_stall` high. `pop_req` is high in its second cycle (the high byte is taken from `stk_rd_data`) and in its third cycle (the low byte). In the fourth cycle, `pc_load` is high with the restored address {high, low}. Push and pop are never high together.
- R7: After a return, the first cycle with `insn_done` high never starts an entry, even with an enabled request pending. The next such cycle may.
- R8: While `insn_done` stays low, as during a multi-cycle instruction, a pending enabled request is not acknowledged.
- R9: After reset, `gie` is 0 and every output is inactive. Outside the hardware set and clear events, `sei_i` sets `gie` and `cli_i` clears it, with clear winning.
- R10: While `gie` is 0, no request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_IRQ | Level-held interrupt requests, bit 0 highest priority |
| sei_i | input | 1 | Software set of the global enable |
| cli_i | input | 1 | Software clear of the global enable |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| reti_dec | input | 1 | Return-from-interrupt decoded |
| pc_cur | input | PC_W | Address of the next instruction to run |
| stk_rd_data | input | PC_W/2 | Byte on top of the stack |
| irq_ack | output | NUM_IRQ | One-hot acknowledge pulse to the winning request |
| gie | output | 1 | Global interrupt enable |
| core_stall | output | 1 | Freezes the core during entry and return |
| jmp_phase | output | 1 | Core is running the two-cycle vector jump |
| push_req | output | 1 | Stack byte write request |
| pop_req | output | 1 | Stack byte read-and-remove request |
| stk_wr_data | output | PC_W/2 | Byte to push |
| pc_load | output | 1 | Load the program counter |
| pc_load_val | output | PC_W | Value to load into the program counter |

## Verification
The hardest case to reach from the ports is a request that is already pending and enabled at the one instruction boundary right after a return. Only there does the one-instruction rule change the outcome. The bench gets there by leaving a lower-priority request held through a whole handler. It issues the return and then pulses `insn_done` every cycle, so that boundary is offered at once. A randomised phase then mixes instruction lengths, re-raised requests, returns and nested handlers. A behavioural model with its own address queue checks every cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENT0,
    ST_ENT1,
    ST_ENT2,
    ST_ENT3,
    ST_JMP0,
    ST_JMP1,
    ST_RET0,
    ST_RET1,
    ST_RET2,
    ST_RET3
  } seq_state_t;

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic [IDX_W-1:0]   win_idx,
  output logic               req_any
);

  // Walk from the top down so the lowest set index is written last.
  always_comb begin
    win_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req[i]) win_idx = IDX_W'(i);
    end
  end

  assign req_any = |req;

  always_comb begin
    if (req_any) begin
      assert_lowest_wins_R1 : assert (req[win_idx]);
    end
  end

endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_clr,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic gie
);

  logic gie_d;
  logic gie_en;

  always_comb begin
    gie_en = hw_clr | hw_set | sw_set | sw_clr;
    if (hw_clr)      gie_d = 1'b0;
    else if (hw_set) gie_d = 1'b1;
    else if (sw_clr) gie_d = 1'b0;
    else             gie_d = sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie <= 1'b0;
    else if (gie_en) gie <= gie_d;
  end

  assert_hw_clr_wins_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !gie);

  assert_hw_set_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !hw_clr) |=> gie);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PC_W    = 16,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BW     = PC_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_done,
  input  logic               reti_dec,
  input  logic               gie,
  input  logic               req_any,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [PC_W-1:0]    pc_cur,
  input  logic [BW-1:0]      stk_rd_data,
  output logic [NUM_IRQ-1:0] ack,
  output logic               gie_clr,
  output logic               gie_set,
  output logic               core_stall,
  output logic               jmp_phase,
  output logic               push_req,
  output logic               pop_req,
  output logic [BW-1:0]      stk_wr_data,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_load_val
);

  seq_state_t        st_q, st_d;
  logic [IDX_W-1:0]  idx_q;
  logic [PC_W-1:0]   ret_pc_q;
  logic [BW-1:0]     pop_hi_q, pop_lo_q;
  logic              hold_q, hold_d, hold_en;
  logic              is_idle, take, start_ret;
  logic [PC_W-1:0]   vec_addr;

  assign is_idle   = (st_q == ST_IDLE);
  assign start_ret = is_idle & reti_dec;
  assign take      = is_idle & ~reti_dec & insn_done & ~hold_q & gie & req_any;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ret) st_d = ST_RET0;
        else if (take) st_d = ST_ENT0;
      end
      ST_ENT0: st_d = ST_ENT1;
      ST_ENT1: st_d = ST_ENT2;
      ST_ENT2: st_d = ST_ENT3;
      ST_ENT3: st_d = ST_JMP0;
      ST_JMP0: st_d = ST_JMP1;
      ST_JMP1: st_d = ST_IDLE;
      ST_RET0: st_d = ST_RET1;
      ST_RET1: st_d = ST_RET2;
      ST_RET2: st_d = ST_RET3;
      ST_RET3: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // one-instruction hold after a return
  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (st_q == ST_RET3) begin
      hold_en = 1'b1;
      hold_d  = 1'b1;
    end else if (is_idle & ~reti_dec & insn_done & hold_q) begin
      hold_en = 1'b1;
      hold_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      ret_pc_q <= '0;
    end else if (take) begin
      idx_q    <= win_idx;
      ret_pc_q <= pc_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pop_hi_q <= '0;
    else if (st_q == ST_RET1)    pop_hi_q <= stk_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pop_lo_q <= '0;
    else if (st_q == ST_RET2)    pop_lo_q <= stk_rd_data;
  end

  // outputs
  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_ack
      assign ack[gi] = (st_q == ST_ENT0) && (idx_q == IDX_W'(gi));
    end
  endgenerate

  assign vec_addr    = {{(PC_W-IDX_W){1'b0}}, idx_q} + PC_W'(1);
  assign gie_clr     = (st_q == ST_ENT0);
  assign gie_set     = (st_q == ST_RET3);
  assign core_stall  = (st_q inside {ST_ENT0, ST_ENT1, ST_ENT2, ST_ENT3,
                                     ST_RET0, ST_RET1, ST_RET2, ST_RET3});
  assign jmp_phase   = (st_q == ST_JMP0) || (st_q == ST_JMP1);
  assign push_req    = (st_q == ST_ENT1) || (st_q == ST_ENT2);
  assign pop_req     = (st_q == ST_RET1) || (st_q == ST_RET2);
  assign stk_wr_data = (st_q == ST_ENT1) ? ret_pc_q[BW-1:0] : ret_pc_q[PC_W-1:BW];
  assign pc_load     = (st_q == ST_ENT3) || (st_q == ST_RET3);
  assign pc_load_val = (st_q == ST_ENT3) ? vec_addr : {pop_hi_q, pop_lo_q};

  assert_ack_onehot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_stall_run_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |=> core_stall);

  assert_no_take_in_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && hold_q) |=> !(|ack));

  assert_jmp_pair_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jmp_phase) |=> jmp_phase);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NUM_IRQ = 8,
  parameter int PC_W    = 16,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BW     = PC_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               insn_done,
  input  logic               reti_dec,
  input  logic [PC_W-1:0]    pc_cur,
  input  logic [BW-1:0]      stk_rd_data,
  output logic [NUM_IRQ-1:0] irq_ack,
  output logic               gie,
  output logic               core_stall,
  output logic               jmp_phase,
  output logic               push_req,
  output logic               pop_req,
  output logic [BW-1:0]      stk_wr_data,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_load_val
);

  logic [IDX_W-1:0] win_idx;
  logic             req_any;
  logic             gie_clr, gie_set;

  irq_prio_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .req     (irq_req),
    .win_idx (win_idx),
    .req_any (req_any)
  );

  irq_gie_ctl u_gie (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_clr (gie_clr),
    .hw_set (gie_set),
    .sw_set (sei_i),
    .sw_clr (cli_i),
    .gie    (gie)
  );

  irq_seq_fsm #(.NUM_IRQ(NUM_IRQ), .PC_W(PC_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done   (insn_done),
    .reti_dec    (reti_dec),
    .gie         (gie),
    .req_any     (req_any),
    .win_idx     (win_idx),
    .pc_cur      (pc_cur),
    .stk_rd_data (stk_rd_data),
    .ack         (irq_ack),
    .gie_clr     (gie_clr),
    .gie_set     (gie_set),
    .core_stall  (core_stall),
    .jmp_phase   (jmp_phase),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .stk_wr_data (stk_wr_data),
    .pc_load     (pc_load),
    .pc_load_val (pc_load_val)
  );

  assert_push_pair_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_req) |=> push_req);

  assert_load_after_push_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && $past(push_req)) |=> (pc_load && core_stall));

  assert_jmp_after_vector_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && $past(push_req)) |=> (jmp_phase && !core_stall));

  assert_gie_drop_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> !gie);

  assert_push_pop_excl_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req && pop_req));

  assert_load_after_pop_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && $past(pop_req)) |=> (pc_load && core_stall));

  assert_boundary_only_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    !insn_done |=> !(|irq_ack));

  assert_gated_by_gie_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !(|irq_ack));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  localparam int NI = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_req;
  logic          sei_i, cli_i, insn_done, reti_dec;
  logic [PW-1:0] pc_cur;
  logic [7:0]    stk_rd_data;
  logic [NI-1:0] irq_ack;
  logic          gie, core_stall, jmp_phase, push_req, pop_req, pc_load;
  logic [7:0]    stk_wr_data;
  logic [PW-1:0] pc_load_val;

  always #5 clk = ~clk;

  irq_entry_seq #(.NUM_IRQ(NI), .PC_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sei_i(sei_i), .cli_i(cli_i),
    .insn_done(insn_done), .reti_dec(reti_dec), .pc_cur(pc_cur),
    .stk_rd_data(stk_rd_data), .irq_ack(irq_ack), .gie(gie),
    .core_stall(core_stall), .jmp_phase(jmp_phase), .push_req(push_req),
    .pop_req(pop_req), .stk_wr_data(stk_wr_data), .pc_load(pc_load),
    .pc_load_val(pc_load_val)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int wd     = 0;

  // reference model: md 0 idle, 1 entry, 2 vector jump, 3 return
  int            md, k, win;
  bit            m_gie, m_hold;
  logic [PW-1:0] ra_q[$];
  logic [7:0]    stk[$];

  function automatic int lowest(input logic [NI-1:0] r);
    for (int i = 0; i < NI; i++) if (r[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    bit hw;
    if (!rst_n) begin
      md = 0; k = 0; win = 0; m_gie = 0; m_hold = 0;
    end else begin
      hw = 0;
      case (md)
        0: begin
          if (reti_dec) begin md = 3; k = 0; end
          else if (insn_done) begin
            if (m_hold) m_hold = 0;
            else if (m_gie && irq_req != 0) begin
              win = lowest(irq_req);
              ra_q.push_back(pc_cur);
              md = 1; k = 0;
            end
          end
        end
        1: begin
          if (k == 0) begin m_gie = 0; hw = 1; end
          if (k == 3) begin md = 2; k = 0; end else k++;
        end
        2: begin
          if (k == 1) begin md = 0; k = 0; end else k++;
        end
        default: begin
          if (k == 3) begin
            m_gie = 1; hw = 1; m_hold = 1;
            void'(ra_q.pop_back());
            md = 0; k = 0;
          end else k++;
        end
      endcase
      if (!hw) begin
        if (cli_i) m_gie = 0;
        else if (sei_i) m_gie = 1;
      end
    end
  end

  task automatic compare_all();
    logic [NI-1:0] e_ack;
    logic [PW-1:0] ra;
    logic [PW-1:0] e_val;
    string t_ld;
    ra    = (ra_q.size() > 0) ? ra_q[ra_q.size()-1] : '0;
    e_ack = (md == 1 && k == 0) ? NI'(1) << win : '0;
    e_val = (md == 1) ? PW'(win + 1) : ra;
    t_ld  = (md == 3) ? "R6" : "R4";
    chk("R2", "irq_ack", PW'(irq_ack), PW'(e_ack));
    chk("R2", "core_stall", PW'(core_stall), PW'(md == 1 || md == 3));
    chk("R3", "push_req", PW'(push_req), PW'(md == 1 && (k == 1 || k == 2)));
    if (md == 1 && k == 1) chk("R3", "push low byte", PW'(stk_wr_data), PW'(ra[7:0]));
    if (md == 1 && k == 2) chk("R3", "push high byte", PW'(stk_wr_data), PW'(ra[15:8]));
    chk(t_ld, "pc_load", PW'(pc_load), PW'((md == 1 || md == 3) && k == 3));
    if (md == 1 && k == 3) chk("R1", "vector address", pc_load_val, e_val);
    if (md == 3 && k == 3) chk("R6", "restored address", pc_load_val, e_val);
    chk("R4", "jmp_phase", PW'(jmp_phase), PW'(md == 2));
    chk("R6", "pop_req", PW'(pop_req), PW'(md == 3 && (k == 1 || k == 2)));
    chk("R5", "gie", PW'(gie), PW'(m_gie));
  endtask

  task automatic step(input bit d, input bit r, input bit s, input bit c);
    @(negedge clk);
    compare_all();
    if (push_req) stk.push_back(stk_wr_data);
    stk_rd_data = (stk.size() > 0) ? stk[stk.size()-1] : 8'h00;
    if (pop_req && stk.size() > 0) void'(stk.pop_back());
    irq_req   = irq_req & ~irq_ack;
    insn_done = d;
    reti_dec  = r;
    sei_i     = s;
    cli_i     = c;
    pc_cur    = pc_cur + 16'h0101;
  endtask

  initial begin
    rst_n = 1'b0; irq_req = '0; sei_i = 0; cli_i = 0; insn_done = 0;
    reti_dec = 0; pc_cur = 16'h3a10; stk_rd_data = 8'h00;
    repeat (3) step(0, 0, 0, 0);
    // R9: reset state at the ports
    chk("R9", "gie after reset", PW'(gie), 0);
    chk("R9", "stall after reset", PW'(core_stall), 0);
    chk("R9", "push/pop/load after reset", PW'({push_req, pop_req, pc_load, jmp_phase}), 0);
    chk("R9", "ack after reset", PW'(irq_ack), 0);
    @(negedge clk) rst_n = 1'b1;

    // R10: requests pending, enable off, boundaries every cycle
    irq_req = 8'b0010_1000;
    repeat (6) step(1, 0, 0, 0);
    chk("R10", "no ack with gie low", PW'(irq_ack), 0);

    // R9: software set, then R8: long instruction with no boundary
    step(0, 0, 1, 0);
    repeat (6) step(0, 0, 0, 0);
    chk("R8", "no ack inside multi-cycle insn", PW'(irq_ack), 0);
    chk("R9", "gie set by software", PW'(gie), 1);

    // R1: boundary arrives, lowest index (3) wins
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R1", "ack on lowest request", PW'(irq_ack), PW'(8'h08));
    repeat (10) step(1, 0, 0, 0);   // entry, jump, handler body with gie low
    step(0, 1, 0, 0);                // return decoded
    repeat (4) step(0, 0, 0, 0);     // four return cycles
    // R7: request 5 still pending; first boundary is the mandatory instruction
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R7", "no entry at first post-return boundary", PW'(core_stall), 0);
    step(0, 0, 0, 0);
    chk("R7", "entry at second boundary", PW'(irq_ack), PW'(8'h20));
    repeat (10) step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    repeat (6) step(0, 0, 0, 0);

    // R9: clear wins over set in the same cycle
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    chk("R9", "cli wins over sei", PW'(gie), 0);
    irq_req = 8'h01;
    repeat (4) step(1, 0, 0, 0);
    chk("R10", "request held while disabled", PW'(irq_req), 1);
    step(0, 0, 1, 0);
    irq_req = 8'hff;

    // randomised phase: mixed insn lengths, re-raised requests, nesting
    for (int n = 0; n < 2000; n++) begin
      bit d, r, s;
      d = ($urandom_range(0, 2) != 0);
      r = (md == 0 && ra_q.size() > 0 && $urandom_range(0, 5) == 0);
      s = (md == 0 && !r && $urandom_range(0, 9) == 0);
      if ($urandom_range(0, 7) == 0) irq_req = irq_req | NI'(1 << $urandom_range(0, NI - 1));
      step(d, r, s, 0);
    end
    // drain: return out of every open handler
    for (int n = 0; n < 400 && (ra_q.size() > 0 || md != 0); n++) begin
      irq_req = '0;
      step(1, (md == 0 && ra_q.size() > 0), 0, 0);
    end
    repeat (3) step(0, 0, 0, 0);
    chk("R6", "stack empty after drain", PW'(stk.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule